// File: doc/BRIEF.md
# Receive Address Filter CAM

This block holds a small table of 48-bit station addresses and decides whether a received destination address belongs to the station. Each entry can be switched in or out of the comparison by one bit of an enable mask. A destination address offered on the match port is compared against every enabled entry at once. One clock later the block reports whether any entry matched and, if so, the index of the matching entry.

Entries are filled by a separate loader through an internal write port, which writes one 16-bit slice of one entry per cycle. Software cannot write entries. It can inspect any entry by writing a 4-bit entry pointer and then reading three 16-bit slice ports, but only while the controller is held in software reset. The enable mask is cleared by hardware reset. Software reset does not touch the mask, and neither reset touches the entries or the pointer.

Top module: `addr_cam`

## Requirements
- R1: The entry pointer takes only bits 3..0 of `ptr_wdata`, with 0h selecting the first entry and Fh the last. The value written can be read back on `ptr_q`.
- R2: While `sw_reset` is low, all three slice read ports return 0000h. While it is high, they return the entry selected by the pointer.
- R3: A loader write changes exactly one 16-bit slice of one entry. The slice select picks the bits: 0 selects 15..0, 1 selects 31..16 and 2 selects 47..32. A write is ignored when `ld_active` is low or the select is 3.
- R4: The enable mask has one bit per entry, and 1 means the entry takes part in matching. Hardware reset clears the mask to zero. Software reset leaves it unchanged. The host loads the mask with `mask_wr`.
- R5: Neither hardware reset nor software reset changes the entry contents or the entry pointer.
- R6: One cycle after `m_valid`, `m_done` is 1. At the same time `m_hit` is 1 exactly when some enabled entry equals `m_addr`. Disabled entries never match.
- R7: When several enabled entries match, `m_idx` reports the lowest index among them.
- R8: When a loader write and a match fall in the same cycle, the match uses the entry contents from before that write.
- R9: The slice ports read bits 47..32 (`rd_hi`), 31..16 (`rd_mid`) and 15..0 (`rd_lo`). The first received octet sits in bits 47..40, so the address with octets 60h,50h,40h,30h,20h,10h in arrival order reads as 6050h, 4030h and 2010h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_rst_n | input | 1 | Hardware reset, active low, synchronous |
| sw_reset | input | 1 | Controller held in software reset |
| ptr_wr | input | 1 | Write strobe for the entry pointer |
| ptr_wdata | input | 16 | Pointer write data; only bits 3..0 are used |
| ptr_q | output | 4 | Current entry pointer |
| mask_wr | input | 1 | Write strobe for the enable mask |
| mask_wdata | input | 16 | Enable mask write data |
| mask_q | output | 16 | Current enable mask |
| rd_hi | output | 16 | Bits 47..32 of the selected entry |
| rd_mid | output | 16 | Bits 31..16 of the selected entry |
| rd_lo | output | 16 | Bits 15..0 of the selected entry |
| ld_active | input | 1 | Loader is running; gates writes |
| ld_wr | input | 1 | Loader slice write strobe |
| ld_idx | input | 4 | Entry index for the loader write |
| ld_sel | input | 2 | Slice select, 0 to 2 |
| ld_data | input | 16 | Slice write data |
| m_valid | input | 1 | Match request |
| m_addr | input | 48 | Destination address to look up |
| m_done | output | 1 | Match result valid |
| m_hit | output | 1 | An enabled entry matched |
| m_idx | output | 4 | Lowest matching index |

## Verification
A loader write and a match lookup can land in the same cycle and target the same entry. The bench provokes this by overwriting a slice of entry 7 in the cycle in which it offers entry 7's old address. The scoreboard expects a hit on the old contents, computed from its model before the write is applied. Two follow-up lookups then expect the old address to miss and the new address to hit.

// File: rtl/addr_cam.sv
module addr_cam #(
  parameter int ENTRIES = 16,
  parameter int SLICE_W = 16,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int ADDR_W = 3 * SLICE_W
) (
  input  logic               clk,
  input  logic               hw_rst_n,
  input  logic               sw_reset,
  input  logic               ptr_wr,
  input  logic [SLICE_W-1:0] ptr_wdata,
  output logic [IDX_W-1:0]   ptr_q,
  input  logic               mask_wr,
  input  logic [ENTRIES-1:0] mask_wdata,
  output logic [ENTRIES-1:0] mask_q,
  output logic [SLICE_W-1:0] rd_hi,
  output logic [SLICE_W-1:0] rd_mid,
  output logic [SLICE_W-1:0] rd_lo,
  input  logic               ld_active,
  input  logic               ld_wr,
  input  logic [IDX_W-1:0]   ld_idx,
  input  logic [1:0]         ld_sel,
  input  logic [SLICE_W-1:0] ld_data,
  input  logic               m_valid,
  input  logic [ADDR_W-1:0]  m_addr,
  output logic               m_done,
  output logic               m_hit,
  output logic [IDX_W-1:0]   m_idx
);

  logic [ENTRIES-1:0][ADDR_W-1:0] mem;
  logic [ADDR_W-1:0]              sel_entry;
  logic                           hit_c;
  logic [IDX_W-1:0]               idx_c;
  logic                           unused_ptr_hi;

  assign unused_ptr_hi = ^ptr_wdata[SLICE_W-1:IDX_W];

  always_ff @(posedge clk)
    if (ptr_wr) ptr_q <= ptr_wdata[IDX_W-1:0];

  always_ff @(posedge clk)
    if (!hw_rst_n)    mask_q <= '0;
    else if (mask_wr) mask_q <= mask_wdata;

  always_ff @(posedge clk)
    if (ld_active && ld_wr)
      for (int k = 0; k < 3; k++)
        if (ld_sel == 2'(k))
          mem[ld_idx][k*SLICE_W +: SLICE_W] <= ld_data;

  assign sel_entry = sw_reset ? mem[ptr_q] : '0;
  assign rd_hi  = sel_entry[3*SLICE_W-1:2*SLICE_W];
  assign rd_mid = sel_entry[2*SLICE_W-1:SLICE_W];
  assign rd_lo  = sel_entry[SLICE_W-1:0];

  always_comb begin
    hit_c = 1'b0;
    idx_c = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (mask_q[i] && mem[i] == m_addr) begin
        hit_c = 1'b1;
        idx_c = IDX_W'(i);
      end
  end

  always_ff @(posedge clk)
    if (!hw_rst_n) begin
      m_done <= 1'b0;
      m_hit  <= 1'b0;
      m_idx  <= '0;
    end else begin
      m_done <= m_valid;
      m_hit  <= m_valid && hit_c;
      m_idx  <= m_valid ? idx_c : '0;
    end

  assert_idle_load_R3: assert property (@(posedge clk) disable iff (!hw_rst_n)
    !(ld_active && ld_wr) |=> $stable(mem));

  assert_mask_hwclr_R4: assert property (@(posedge clk)
    !hw_rst_n |=> mask_q == '0);

  assert_mask_hold_R4: assert property (@(posedge clk) disable iff (!hw_rst_n)
    !mask_wr |=> $stable(mask_q));

  assert_ptr_keep_R5: assert property (@(posedge clk) disable iff (!hw_rst_n)
    !ptr_wr |=> $stable(ptr_q));

  assert_done_R6: assert property (@(posedge clk) disable iff (!hw_rst_n)
    m_valid |=> m_done);

  assert_hit_done_R6: assert property (@(posedge clk) disable iff (!hw_rst_n)
    m_hit |-> m_done);

  assert_hit_enabled_R6: assert property (@(posedge clk) disable iff (!hw_rst_n)
    m_hit |-> ((($past(mask_q) >> m_idx) & 1) != 0));

endmodule

// File: tb/test_addr_cam.sv
module test_addr_cam;
  logic        clk = 0;
  logic        hw_rst_n = 0, sw_reset = 0;
  logic        ptr_wr = 0;
  logic [15:0] ptr_wdata = '0;
  logic [3:0]  ptr_q;
  logic        mask_wr = 0;
  logic [15:0] mask_wdata = '0, mask_q;
  logic [15:0] rd_hi, rd_mid, rd_lo;
  logic        ld_active = 0, ld_wr = 0;
  logic [3:0]  ld_idx = '0;
  logic [1:0]  ld_sel = '0;
  logic [15:0] ld_data = '0;
  logic        m_valid = 0;
  logic [47:0] m_addr = '0;
  logic        m_done, m_hit;
  logic [3:0]  m_idx;

  int total = 0, bad = 0;
  logic [47:0] model [16];
  logic [15:0] mmask;
  logic [4:0]  expq [$];

  always #5 clk = ~clk;

  addr_cam i_addr_cam (.*);

  task automatic check(string tag, logic [47:0] act, logic [47:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [47:0] ent(int i);
    return 48'h605040302010 + 48'(i) * 48'h000100010001;
  endfunction

  function automatic logic [4:0] expect_match(logic [47:0] a);
    for (int i = 0; i < 16; i++)
      if (mmask[i] && model[i] == a) return {1'b1, 4'(i)};
    return 5'b0;
  endfunction

  task automatic slice_wr(logic act, int i, int s, logic [15:0] d);
    @(negedge clk);
    ld_active = act; ld_wr = 1; ld_idx = 4'(i); ld_sel = 2'(s); ld_data = d;
    if (act && s < 3) model[i][s*16 +: 16] = d;
    @(negedge clk);
    ld_wr = 0; ld_active = 0;
  endtask

  task automatic load_entry(int i, logic [47:0] v);
    for (int s = 0; s < 3; s++) slice_wr(1, i, s, v[s*16 +: 16]);
  endtask

  task automatic set_mask(logic [15:0] m);
    @(negedge clk); mask_wr = 1; mask_wdata = m; mmask = m;
    @(negedge clk); mask_wr = 0;
  endtask

  task automatic read_entry(string tag, logic [15:0] pv, int i);
    @(negedge clk); ptr_wr = 1; ptr_wdata = pv;
    @(negedge clk); ptr_wr = 0;
    check(tag, {rd_hi, rd_mid, rd_lo}, model[i]);
    check({tag, " ptr"}, 48'(ptr_q), 48'(i));
  endtask

  task automatic do_match(logic [47:0] a, logic with_ld, int li, int ls, logic [15:0] ld);
    @(negedge clk);
    expq.push_back(expect_match(a));
    m_valid = 1; m_addr = a;
    if (with_ld) begin
      ld_active = 1; ld_wr = 1; ld_idx = 4'(li); ld_sel = 2'(ls); ld_data = ld;
      model[li][ls*16 +: 16] = ld;
    end
    @(negedge clk);
    m_valid = 0; ld_wr = 0; ld_active = 0;
  endtask

  always @(negedge clk) if (hw_rst_n && m_done) begin
    logic [4:0] e;
    if (expq.size() == 0) check("R6 unexpected result", 48'(1), 48'(0));
    else begin
      e = expq.pop_front();
      check("R6 R7 R8 match", 48'({m_hit, m_hit ? m_idx : 4'h0}), 48'(e));
    end
  end

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    mmask = '0;
    repeat (3) @(negedge clk);
    check("R4 hw reset mask", 48'(mask_q), 48'(0));
    check("R6 done idle", 48'(m_done), 48'(0));
    hw_rst_n = 1;
    for (int i = 0; i < 16; i++) load_entry(i, ent(i));
    sw_reset = 1;
    read_entry("R9 packing", 16'h0000, 0);
    check("R9 hi", 48'(rd_hi), 48'h6050);
    check("R9 mid", 48'(rd_mid), 48'h4030);
    check("R9 lo", 48'(rd_lo), 48'h2010);
    read_entry("R1 last entry", 16'h000F, 15);
    read_entry("R1 upper bits ignored", 16'hFFF5, 5);
    sw_reset = 0;
    @(negedge clk);
    check("R2 gated read", {rd_hi, rd_mid, rd_lo}, 48'h0);
    slice_wr(0, 5, 1, 16'hDEAD);
    slice_wr(1, 5, 3, 16'hBEEF);
    sw_reset = 1;
    read_entry("R3 ignored writes", 16'h0005, 5);
    slice_wr(1, 5, 2, 16'hA5A5);
    read_entry("R3 single slice", 16'h0005, 5);
    do_match(ent(3), 0, 0, 0, 0);
    set_mask(16'hFFFF);
    do_match(ent(3), 0, 0, 0, 0);
    do_match(48'h123456789ABC, 0, 0, 0, 0);
    load_entry(9, ent(4));
    do_match(ent(4), 0, 0, 0, 0);
    set_mask(16'hFFEF);
    do_match(ent(4), 0, 0, 0, 0);
    do_match(ent(3), 0, 0, 0, 0);
    do_match(ent(7), 1, 7, 0, 16'h7777);
    do_match(ent(7), 0, 0, 0, 0);
    do_match(model[7], 0, 0, 0, 0);
    @(negedge clk); sw_reset = 1;
    @(negedge clk); sw_reset = 0;
    @(negedge clk);
    check("R4 sw reset keeps mask", 48'(mask_q), 48'(16'hFFEF));
    @(negedge clk); hw_rst_n = 0;
    @(negedge clk); hw_rst_n = 1;
    check("R4 hw reset clears mask", 48'(mask_q), 48'(0));
    mmask = '0;
    sw_reset = 1;
    @(negedge clk);
    check("R5 ptr kept", 48'(ptr_q), 48'(5));
    check("R5 entry kept", {rd_hi, rd_mid, rd_lo}, model[5]);
    read_entry("R5 entry 7 kept", 16'h0007, 7);
    sw_reset = 0;
    do_match(model[7], 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    check("R6 queue drained", 48'(expq.size()), 48'(0));
    finish_run();
  end
endmodule